// File: doc/BRIEF.md
# Reset Source Arbitration Controller

This block merges the chip's reset requests into one internal system reset. The requests are a power-on reset, a low-voltage request, a bus-reset detection from the USB function and a synchronous request from elsewhere in the chip, such as a watchdog. A configuration input decides how a detected USB bus reset is handled. It either resets the whole chip or raises an interrupt flag that software must acknowledge. While the USB function is disabled, a bus reset has no effect at all.

Register bits fall into two reset domains. Ordinary bits clear on every reset. A second group clears only when power-on or low-voltage is the cause, which lets configuration such as the USB enable survive a watchdog or bus reset. Storage with no defined reset value, such as data buffers and port latches, takes neither clear. The block drives one clear level for each domain. It also keeps a record of reset causes that is cleared when read. The asynchronous requests are synchronized, and every reset is stretched to a minimum number of cycles.

Top module: `rst_arbiter`

## Requirements
- R1: While `por_n` is low, `sys_rst`, `rst_norm_clr` and `rst_keep_clr` are 1 and `cause` is 4'b0001 (bit 0 = power-on, bit 1 = low-voltage, bit 2 = USB bus reset, bit 3 = other request). After `por_n` rises, the reset stays asserted for exactly STRETCH cycles.
- R2: A rising edge on `bus_rst_det` with `usb_en`=1 and `bus_rst_to_irq`=0 asserts `sys_rst` three clock edges after the input changes, for STRETCH cycles. It sets cause bit 2 and does not assert `rst_keep_clr`.
- R3: A rising edge on `bus_rst_det` with `usb_en`=1 and `bus_rst_to_irq`=1 sets `bus_irq` three edges later and does not assert `sys_rst`.
- R4: A rising edge on `bus_rst_det` while `usb_en`=0 changes neither `sys_rst`, `bus_irq` nor `cause`, whatever `bus_rst_to_irq` is.
- R5: `soft_rst_req` high at a clock edge asserts `sys_rst` after that edge. It sets cause bit 3 and does not assert `rst_keep_clr`.
- R6: A high level on `lvi_req` lasting L cycles asserts `sys_rst` and `rst_keep_clr` three edges after it rises, for L-1+STRETCH cycles in total. It sets cause bit 1.
- R7: Every new request reloads the stretch, so `sys_rst` stays high for STRETCH cycles after the last request, and never for fewer than STRETCH cycles.
- R8: `bus_irq` stays set until `irq_ack` is high at an edge. If a new interrupt event arrives at the same edge as the acknowledge, the flag stays set.
- R9: Any system reset clears `bus_irq`, and the flag cannot be set while the reset is active. An interrupt event at the same edge as a reset request leaves the flag clear.
- R10: `cause_rd` high at an edge clears the cause bits. A cause that arrives at the same edge is kept.
- R11: `rst_norm_clr` is high during every system reset. `rst_keep_clr` is high only while a reset whose episode includes a power-on or low-voltage cause is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lvi_req | input | 1 | Asynchronous low-voltage reset request, active high |
| bus_rst_det | input | 1 | Asynchronous USB bus-reset detection level |
| usb_en | input | 1 | USB function enable |
| bus_rst_to_irq | input | 1 | 1: bus reset raises an interrupt instead of a reset |
| soft_rst_req | input | 1 | Synchronous reset request from other chip logic |
| irq_ack | input | 1 | Clears the bus-reset interrupt flag |
| cause_rd | input | 1 | Read strobe that clears the cause record |
| sys_rst | output | 1 | Internal system reset, active high |
| rst_norm_clr | output | 1 | Clear for registers reset by every reset |
| rst_keep_clr | output | 1 | Clear for registers reset only by power-on or low voltage |
| bus_irq | output | 1 | USB bus-reset interrupt flag |
| cause | output | 4 | Reset cause record {other, usb, low-voltage, power-on} |

## Verification
Two pairs of events can fall on the same edge. The first pair is a bus-reset interrupt event and a reset request. The second is a new interrupt event and its acknowledge. The bench raises `bus_rst_det` and then drives `soft_rst_req` or `irq_ack` exactly two cycles later, so that both reach the same edge. In the first case it expects the flag to stay clear and the reset to win. In the second it expects the flag to stay set. A third collision, a cause read in the same cycle as a new reset, is judged by the cause record, which must hold only the new cause.

// File: rtl/rst_arbiter.sv
module rst_arbiter #(
  parameter int STRETCH     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lvi_req,
  input  logic       bus_rst_det,
  input  logic       usb_en,
  input  logic       bus_rst_to_irq,
  input  logic       soft_rst_req,
  input  logic       irq_ack,
  input  logic       cause_rd,
  output logic       sys_rst,
  output logic       rst_norm_clr,
  output logic       rst_keep_clr,
  output logic       bus_irq,
  output logic [3:0] cause
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [SYNC_STAGES-1:0] lvi_sh, bus_sh;
  logic bus_d, keep_q, irq_q;
  logic [CW-1:0] cnt, cnt_nx;
  logic lvi_s, bus_s, bus_hit, bus_reset, bus_int, trig;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      lvi_sh <= '0;
      bus_sh <= '0;
      bus_d  <= 1'b0;
    end else begin
      lvi_sh <= SYNC_STAGES'({lvi_sh, lvi_req});
      bus_sh <= SYNC_STAGES'({bus_sh, bus_rst_det});
      bus_d  <= bus_s;
    end

  assign lvi_s     = lvi_sh[SYNC_STAGES-1];
  assign bus_s     = bus_sh[SYNC_STAGES-1];
  assign bus_hit   = usb_en & bus_s & ~bus_d;
  assign bus_reset = bus_hit & ~bus_rst_to_irq;
  assign bus_int   = bus_hit & bus_rst_to_irq;
  assign trig      = lvi_s | bus_reset | soft_rst_req;
  assign cnt_nx    = trig ? LOAD : (cnt != '0 ? cnt - CW'(1) : cnt);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cnt    <= LOAD;
      keep_q <= 1'b1;
      irq_q  <= 1'b0;
      cause  <= 4'b0001;
    end else begin
      cnt    <= cnt_nx;
      keep_q <= lvi_s | (keep_q & (cnt_nx != '0));
      if (trig || sys_rst) irq_q <= 1'b0;
      else if (bus_int)    irq_q <= 1'b1;
      else if (irq_ack)    irq_q <= 1'b0;
      cause  <= (cause & ~{4{cause_rd}}) | {soft_rst_req, bus_reset, lvi_s, 1'b0};
    end

  assign sys_rst      = cnt != '0;
  assign rst_norm_clr = sys_rst;
  assign rst_keep_clr = sys_rst & keep_q;
  assign bus_irq      = irq_q;
endmodule

module rst_arbiter_chk #(
  parameter int STRETCH = 8
) (
  input logic clk,
  input logic por_n,
  input logic soft_rst_req,
  input logic usb_en,
  input logic bus_rst_to_irq,
  input logic cause_rd,
  input logic sys_rst,
  input logic rst_keep_clr,
  input logic bus_irq,
  input logic cause_other
);
  logic [15:0] run;
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) run <= '0;
    else run <= sys_rst ? ((run == 16'hFFFF) ? run : run + 16'd1) : 16'd0;

  // R7
  min_stretch_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> 32'(run) >= STRETCH);
  // R11
  keep_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_keep_clr |-> sys_rst);
  // R5
  soft_req_chk: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst_req |=> sys_rst);
  // R9
  irq_vs_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_irq && sys_rst));
  // R3
  irq_source_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bus_irq) |-> $past(usb_en && bus_rst_to_irq));
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cause_rd && !soft_rst_req) |=> !cause_other);
endmodule

bind rst_arbiter rst_arbiter_chk #(.STRETCH(STRETCH)) chk_i (
  .clk(clk), .por_n(por_n), .soft_rst_req(soft_rst_req), .usb_en(usb_en),
  .bus_rst_to_irq(bus_rst_to_irq), .cause_rd(cause_rd), .sys_rst(sys_rst),
  .rst_keep_clr(rst_keep_clr), .bus_irq(bus_irq), .cause_other(cause[3]));

// File: tb/rst_arbiter_test.sv
`timescale 1ns/1ps
module rst_arbiter_test;
  localparam int S = 8;
  logic clk = 0, por_n = 0, lvi_req = 0, bus_rst_det = 0, usb_en = 0, bus_rst_to_irq = 0;
  logic soft_rst_req = 0, irq_ack = 0, cause_rd = 0;
  logic sys_rst, rst_norm_clr, rst_keep_clr, bus_irq;
  logic [3:0] cause;
  int checks = 0, fails = 0, hi_cnt = 0, keep_cnt = 0, norm_cnt = 0;
  bit done = 0;

  rst_arbiter #(.STRETCH(S), .SYNC_STAGES(2)) uut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) begin
    if (sys_rst) hi_cnt++;
    if (rst_keep_clr) keep_cnt++;
    if (rst_norm_clr) norm_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    bus_rst_det = 0; lvi_req = 0; soft_rst_req = 0;
    step(1);
    while (sys_rst) step(1);
    irq_ack = 1; cause_rd = 1; step(1);
    irq_ack = 0; cause_rd = 0; step(3);
    hi_cnt = 0; keep_cnt = 0; norm_cnt = 0;
  endtask

  task automatic soft_pulse();
    soft_rst_req = 1; step(1); soft_rst_req = 0;
  endtask

  function automatic int exp_len(input int kind, input bit en, input bit toi, input int l);
    if (kind == 0) return S;
    if (kind == 1) return (en && !toi) ? S : 0;
    return l - 1 + S;
  endfunction

  initial begin
    int n;
    n = 0;
    void'($urandom(32'd20240));
    step(3);
    chk("R1 sys_rst in por", sys_rst, 1);
    chk("R1 keep clr in por", rst_keep_clr, 1);
    chk("R1 norm clr in por", rst_norm_clr, 1);
    chk("R1 cause in por", cause, 1);
    chk("R1 irq in por", bus_irq, 0);
    por_n = 1; #1;
    while (sys_rst && n < 1000) begin n++; @(negedge clk); end
    chk("R1 stretch after por", n, S);
    chk("R1 cause kept", cause, 1);
    cause_rd = 1; step(1); cause_rd = 0;
    chk("R10 read clears", cause, 0);
    quiet();

    soft_pulse();
    chk("R5 reset after one edge", sys_rst, 1);
    chk("R5 no keep clr", rst_keep_clr, 0);
    step(1); while (sys_rst) step(1);
    chk("R7 soft length", hi_cnt, S);
    chk("R11 norm equals reset", norm_cnt, S);
    chk("R11 keep unused", keep_cnt, 0);
    chk("R5 cause other", cause, 8);
    quiet();

    usb_en = 1; bus_rst_to_irq = 0; bus_rst_det = 1;
    step(2); chk("R2 not yet", sys_rst, 0);
    step(1); chk("R2 reset at third edge", sys_rst, 1);
    while (sys_rst) step(1);
    chk("R2 length", hi_cnt, S);
    chk("R2 no keep", keep_cnt, 0);
    chk("R2 cause usb", cause, 4);
    cause_rd = 1; soft_rst_req = 1; step(1); cause_rd = 0; soft_rst_req = 0;
    chk("R10 event wins read", cause, 8);
    quiet();

    usb_en = 1; bus_rst_to_irq = 1; bus_rst_det = 1;
    step(3);
    chk("R3 irq set", bus_irq, 1);
    chk("R3 no reset", sys_rst, 0);
    step(5); chk("R8 irq held", bus_irq, 1);
    chk("R3 no reset later", hi_cnt, 0);
    irq_ack = 1; step(1); irq_ack = 0;
    chk("R8 ack clears", bus_irq, 0);
    quiet();

    for (int m = 0; m < 2; m++) begin
      usb_en = 0; bus_rst_to_irq = m[0]; bus_rst_det = 1;
      step(6);
      chk("R4 no reset when disabled", hi_cnt, 0);
      chk("R4 no irq when disabled", bus_irq, 0);
      chk("R4 cause untouched", cause, 0);
      quiet();
    end

    lvi_req = 1; step(3);
    chk("R6 reset", sys_rst, 1);
    chk("R6 keep clr", rst_keep_clr, 1);
    step(2); lvi_req = 0;
    step(1); while (sys_rst) step(1);
    chk("R6 length", hi_cnt, 4 + S);
    chk("R11 keep length", keep_cnt, 4 + S);
    chk("R6 cause lvi", cause, 2);
    quiet();

    usb_en = 1; bus_rst_to_irq = 1; bus_rst_det = 1;
    step(2); soft_rst_req = 1; step(1); soft_rst_req = 0;
    chk("R9 reset wins", sys_rst, 1);
    chk("R9 irq clear on collision", bus_irq, 0);
    while (sys_rst) step(1);
    chk("R9 irq clear after", bus_irq, 0);
    quiet();

    usb_en = 1; bus_rst_to_irq = 1; bus_rst_det = 1;
    step(3); chk("R3 irq before reset", bus_irq, 1);
    soft_pulse(); chk("R9 reset clears irq", bus_irq, 0);
    quiet();

    usb_en = 1; bus_rst_to_irq = 1; bus_rst_det = 1;
    step(2); irq_ack = 1; step(1); irq_ack = 0;
    chk("R8 set beats ack", bus_irq, 1);
    quiet();

    soft_pulse(); step(2); soft_pulse();
    step(1); while (sys_rst) step(1);
    chk("R7 retrigger", hi_cnt, 3 + S);
    quiet();

    soft_pulse(); step(1); lvi_req = 1; step(1); lvi_req = 0;
    step(1); while (sys_rst) step(1);
    chk("R11 low voltage upgrades", (keep_cnt > 0) ? 1 : 0, 1);
    quiet();

    for (int it = 0; it < 200; it++) begin
      int kind, l;
      bit en, toi;
      kind = $urandom % 3;
      en = $urandom % 2;
      toi = $urandom % 2;
      l = 1 + $urandom % 6;
      usb_en = en; bus_rst_to_irq = toi;
      if (kind == 0) soft_pulse();
      else if (kind == 1) begin bus_rst_det = 1; step(4); end
      else begin lvi_req = 1; step(l); lvi_req = 0; end
      step(3); while (sys_rst) step(1);
      chk("R7 random length", hi_cnt, exp_len(kind, en, toi, l));
      chk("R11 random keep", keep_cnt, (kind == 2) ? exp_len(kind, en, toi, l) : 0);
      chk("R3 random irq", bus_irq, (kind == 1 && en && toi) ? 1 : 0);
      chk("R10 random cause", cause,
          kind == 0 ? 8 : kind == 2 ? 2 : (en && !toi) ? 4 : 0);
      quiet();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule